// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the device side of a byte-wide parallel NOR flash and watches every write strobe the host issues. Commands must start with a two-write unlock handshake; the decoder then follows the chosen path and, when a sequence completes, raises one of four single-cycle requests towards the array controller: byte program, chip erase, sector erase or boot-block lockout set. Each request carries the target address, the data byte and a five-bit sector mask.

A sticky lockout bit guards the top 16 KB boot sector. While it is set, and the override input is low, program and sector-erase requests aimed at that sector are dropped, and a chip erase leaves it out of its mask. The decoder also holds a software identification mode. In that mode reads of the three lowest addresses are taken over, so that the host sees the identification codes and the lockout state instead of array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the active-low reset no request is raised and identification mode is off; the lockout bit keeps its value through reset.
- R2: A command starts only with data AA written at command offset 5555 followed by data 55 at offset 2AAA. Only address bits 14..0 are compared for command offsets, so bits 17..15 do not matter.
- R3: Unlock followed by A0 at 5555 arms a byte program. The next write raises prog_req for exactly one cycle after its clock edge, with op_addr and op_data equal to that write's address and data. At most one request is high in any cycle.
- R4: Unlock, 80 at 5555, AA at 5555, 55 at 2AAA, then 10 at 5555 raises chip_erase_req. erase_mask is 1F when unlocked or overridden, and 0F when locked.
- R5: The same six-write group ending in 30 at any address raises sector_erase_req with a one-hot erase_mask for that address. Bit 0 covers 00000-1FFFF, bit 1 covers 20000-37FFF, bit 2 covers 38000-39FFF, bit 3 covers 3A000-3BFFF and bit 4 covers the boot sector 3C000-3FFFF.
- R6: The six-write group ending in 40 at 5555 raises lock_set_req and sets the lockout bit, which then stays set.
- R7: While the lockout bit is set and lock_override is low, a program or sector erase aimed at 3C000-3FFFF raises no request and the decoder returns to idle. With lock_override high, the same commands proceed.
- R8: Unlock followed by 90 at 5555 enters identification mode. While rd_en is high in that mode, rd_addr 0 returns DA, 1 returns 0B and 2 returns the lockout bit in bit 0 (1 means locked), each with id_hit high. Any other address leaves id_hit low.
- R9: Identification mode is left either by unlock followed by F0 at 5555, or by a single F0 write at any address from any step other than the program-target step. The override of reads holds for the whole cycle in which the exit write is taken.
- R10: A write that does not match the expected address and data for the current step returns the decoder to idle.
- R11: Writes taken while busy is high are ignored and leave the decoder step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 18 | Read address |
| busy | input | 1 | Array controller busy, writes ignored |
| lock_override | input | 1 | Suspends boot-sector lockout while high |
| prog_req | output | 1 | Byte program request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sector_erase_req | output | 1 | Sector erase request pulse |
| lock_set_req | output | 1 | Lockout set request pulse |
| op_addr | output | 18 | Address of the last request |
| op_data | output | 8 | Data byte of the last request |
| erase_mask | output | 5 | Sectors to erase for the last erase request |
| id_mode | output | 1 | Identification mode active |
| id_hit | output | 1 | Read is answered by the decoder |
| id_data | output | 8 | Identification read data |

## Verification
A read strobe and a write that leaves or enters identification mode can be taken in the same cycle. The bench drives rd_en together with a single F0 exit write and checks that id_hit stays high through that cycle, then drops on the next read. A busy flag can likewise rise together with the final write of a sequence. The bench drives it on a program target and checks that no request appears and that the next write taken while idle still completes the program. Random command streams, with corrupted steps, random busy and random override, are compared write by write against a reference model in the bench.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter logic [7:0] MFR_CODE  = 8'hDA,
  parameter logic [7:0] DEV_CODE  = 8'h0B,
  parameter bit         LOCK_INIT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [17:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [17:0] rd_addr,
  input  logic        busy,
  input  logic        lock_override,
  output logic        prog_req,
  output logic        chip_erase_req,
  output logic        sector_erase_req,
  output logic        lock_set_req,
  output logic [17:0] op_addr,
  output logic [7:0]  op_data,
  output logic [4:0]  erase_mask,
  output logic        id_mode,
  output logic        id_hit,
  output logic [7:0]  id_data
);
  localparam logic [14:0] OFS_A = 15'h5555;
  localparam logic [14:0] OFS_B = 15'h2AAA;
  localparam logic [7:0] K_UNL1 = 8'hAA, K_UNL2 = 8'h55, K_PROG = 8'hA0;
  localparam logic [7:0] K_ERS = 8'h80, K_IDIN = 8'h90, K_EXIT = 8'hF0;
  localparam logic [7:0] K_CHIP = 8'h10, K_SECT = 8'h30, K_LOCK = 8'h40;
  localparam logic [4:0] ALL_SECT  = 5'h1F;
  localparam logic [4:0] BOOT_SECT = 5'h10;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5
  } step_t;

  step_t      step_q, step_d;
  logic       id_q, id_d;
  logic       lock_q = LOCK_INIT;
  logic       p_d, c_d, s_d, l_d;
  logic [4:0] mask_d;

  function automatic logic [4:0] sector_of(input logic [17:0] a);
    if (!a[17])                 return 5'b00001;
    else if (a[17:13] < 5'h1C)  return 5'b00010;
    else if (a[17:13] == 5'h1C) return 5'b00100;
    else if (a[17:13] == 5'h1D) return 5'b01000;
    else                        return 5'b10000;
  endfunction

  wire        take     = wr_en && !busy;
  wire        at_a     = wr_addr[14:0] == OFS_A;
  wire        at_b     = wr_addr[14:0] == OFS_B;
  wire        is_exit  = wr_data == K_EXIT;
  wire [4:0]  wr_sect  = sector_of(wr_addr);
  wire        guard    = lock_q && !lock_override;
  wire        blocked  = guard && wr_sect[4];

  always_comb begin
    step_d = step_q;
    id_d   = id_q;
    p_d    = 1'b0;
    c_d    = 1'b0;
    s_d    = 1'b0;
    l_d    = 1'b0;
    mask_d = '0;
    if (take) begin
      step_d = S_IDLE;
      case (step_q)
        S_IDLE: begin
          if (is_exit)                       id_d = 1'b0;
          else if (at_a && wr_data == K_UNL1) step_d = S_U1;
        end
        S_U1: begin
          if (is_exit)                       id_d = 1'b0;
          else if (at_b && wr_data == K_UNL2) step_d = S_U2;
        end
        S_U2: begin
          if (at_a && wr_data == K_PROG)      step_d = S_PROG;
          else if (at_a && wr_data == K_ERS)  step_d = S_E3;
          else if (at_a && wr_data == K_IDIN) id_d = 1'b1;
          else if (is_exit)                  id_d = 1'b0;
        end
        S_PROG: p_d = !blocked;
        S_E3: begin
          if (is_exit)                       id_d = 1'b0;
          else if (at_a && wr_data == K_UNL1) step_d = S_E4;
        end
        S_E4: begin
          if (is_exit)                       id_d = 1'b0;
          else if (at_b && wr_data == K_UNL2) step_d = S_E5;
        end
        S_E5: begin
          if (at_a && wr_data == K_CHIP) begin
            c_d    = 1'b1;
            mask_d = guard ? (ALL_SECT & ~BOOT_SECT) : ALL_SECT;
          end else if (at_a && wr_data == K_LOCK) begin
            l_d = 1'b1;
          end else if (wr_data == K_SECT) begin
            s_d    = !blocked;
            mask_d = wr_sect;
          end else if (is_exit) begin
            id_d = 1'b0;
          end
        end
        default: step_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q           <= S_IDLE;
      id_q             <= 1'b0;
      prog_req         <= 1'b0;
      chip_erase_req   <= 1'b0;
      sector_erase_req <= 1'b0;
      lock_set_req     <= 1'b0;
      op_addr          <= '0;
      op_data          <= '0;
      erase_mask       <= '0;
    end else begin
      step_q           <= step_d;
      id_q             <= id_d;
      prog_req         <= p_d;
      chip_erase_req   <= c_d;
      sector_erase_req <= s_d;
      lock_set_req     <= l_d;
      if (p_d || c_d || s_d || l_d) begin
        op_addr    <= wr_addr;
        op_data    <= wr_data;
        erase_mask <= mask_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (l_d) lock_q <= 1'b1;
  end

  assign id_mode = id_q;
  assign id_hit  = id_q && rd_en && (rd_addr < 18'd3);
  always_comb begin
    case (rd_addr[1:0])
      2'd0:    id_data = MFR_CODE;
      2'd1:    id_data = DEV_CODE;
      default: id_data = {7'd0, lock_q};
    endcase
  end

  a_r3_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sector_erase_req, lock_set_req}));
  a_r3_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  a_r11_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || chip_erase_req || sector_erase_req || lock_set_req)
      |-> $past(wr_en && !busy));
  a_r7_boot_prog_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && op_addr[17:14] == 4'hF) |-> !$past(lock_q && !lock_override));
  a_r7_boot_sect_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_erase_req && erase_mask[4]) |-> !$past(lock_q && !lock_override));
  a_r4_chip_mask: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |-> (erase_mask[3:0] == 4'hF &&
                        erase_mask[4] == !$past(lock_q && !lock_override)));
  a_r5_sector_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_req |-> $countones(erase_mask) == 1);
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);
  a_r6_lock_after_set: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_req |-> lock_q);
  a_r8_hit_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> (id_mode && rd_en));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0, lock_override = 1'b0;
  logic [17:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic prog_req, chip_erase_req, sector_erase_req, lock_set_req;
  logic [17:0] op_addr;
  logic [7:0]  op_data, id_data;
  logic [4:0]  erase_mask;
  logic id_mode, id_hit;

  always #2 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
    .lock_override(lock_override), .prog_req(prog_req),
    .chip_erase_req(chip_erase_req), .sector_erase_req(sector_erase_req),
    .lock_set_req(lock_set_req), .op_addr(op_addr), .op_data(op_data),
    .erase_mask(erase_mask), .id_mode(id_mode), .id_hit(id_hit),
    .id_data(id_data));

  int checks = 0, errors = 0;
  int m_st = 0;
  bit m_id = 0, m_lock = 0;
  logic [3:0] exp_req;
  logic [4:0] exp_mask;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] sect(input logic [17:0] a);
    if (a < 18'h20000)      return 5'b00001;
    else if (a < 18'h38000) return 5'b00010;
    else if (a < 18'h3A000) return 5'b00100;
    else if (a < 18'h3C000) return 5'b01000;
    else                    return 5'b10000;
  endfunction

  task automatic model(input logic [17:0] a, input logic [7:0] d,
                       input bit bz, input bit ov);
    bit pa, pb, g;
    pa = a[14:0] == 15'h5555;
    pb = a[14:0] == 15'h2AAA;
    g  = m_lock && !ov;
    exp_req = 4'b0; exp_mask = 5'b0;
    if (bz) return;
    case (m_st)
      0: begin m_st = 0; if (d == 8'hF0) m_id = 0; else if (pa && d == 8'hAA) m_st = 1; end
      1: begin m_st = 0; if (d == 8'hF0) m_id = 0; else if (pb && d == 8'h55) m_st = 2; end
      2: begin
        m_st = 0;
        if (pa && d == 8'hA0) m_st = 3;
        else if (pa && d == 8'h80) m_st = 4;
        else if (pa && d == 8'h90) m_id = 1;
        else if (d == 8'hF0) m_id = 0;
      end
      3: begin m_st = 0; if (!(g && sect(a) == 5'b10000)) exp_req = 4'b1000; end
      4: begin m_st = 0; if (d == 8'hF0) m_id = 0; else if (pa && d == 8'hAA) m_st = 5; end
      5: begin m_st = 0; if (d == 8'hF0) m_id = 0; else if (pb && d == 8'h55) m_st = 6; end
      default: begin
        m_st = 0;
        if (pa && d == 8'h10) begin exp_req = 4'b0100; exp_mask = g ? 5'h0F : 5'h1F; end
        else if (pa && d == 8'h40) begin exp_req = 4'b0001; m_lock = 1; end
        else if (d == 8'h30) begin
          exp_mask = sect(a);
          if (!(g && sect(a) == 5'b10000)) exp_req = 4'b0010;
        end else if (d == 8'hF0) m_id = 0;
      end
    endcase
  endtask

  function automatic string tag_of(input logic [3:0] r, input bit bz);
    if (r[3]) return "R3";
    if (r[2]) return "R4";
    if (r[1]) return "R5";
    if (r[0]) return "R6";
    return bz ? "R11" : "R10";
  endfunction

  task automatic wr(input logic [17:0] a, input logic [7:0] d,
                    input bit bz = 0, input bit ov = 0);
    logic [3:0] got;
    bit ok;
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; busy = bz; lock_override = ov;
    model(a, d, bz, ov);
    @(negedge clk);
    wr_en = 0; busy = 0; lock_override = 0;
    got = {prog_req, chip_erase_req, sector_erase_req, lock_set_req};
    ok = (got === exp_req) && (id_mode === m_id);
    if (exp_req != 0)
      ok = ok && op_addr === a && op_data === d &&
           (!(exp_req[2] || exp_req[1]) || erase_mask === exp_mask);
    chk(ok, tag_of(exp_req, bz), {got, 3'b0, id_mode, op_addr, 6'b0},
        {exp_req, 3'b0, m_id, a, 6'b0});
  endtask

  task automatic rd(input logic [17:0] a, input string tag);
    logic [7:0] ed;
    bit eh;
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    #1;
    eh = m_id && a < 3;
    ed = (a == 0) ? 8'hDA : (a == 1) ? 8'h0B : {7'd0, m_lock};
    chk(id_hit === eh && (!eh || id_data === ed), tag, {id_hit, id_data},
        {eh, ed});
    rd_en = 0;
  endtask

  task automatic unlock(input logic [2:0] up = 3'd0);
    wr({up, 15'h5555}, 8'hAA);
    wr({up, 15'h2AAA}, 8'h55);
  endtask

  task automatic grp(input logic [17:0] a, input logic [7:0] d,
                     input bit ov = 0);
    unlock();
    wr(18'h05555, 8'h80);
    unlock();
    wr(a, d, 0, ov);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_st = 0; m_id = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({prog_req, chip_erase_req, sector_erase_req, lock_set_req, id_mode} === 5'b0,
        "R1 reset idle", {prog_req, chip_erase_req, sector_erase_req, lock_set_req, id_mode}, 0);

    // R2 upper address bits ignored; R3 program
    unlock(3'd5);
    wr(18'h25555, 8'hA0);
    wr(18'h00123, 8'h5A);
    chk(prog_req && op_addr == 18'h00123 && op_data == 8'h5A, "R3 program",
        {op_addr, op_data}, {18'h00123, 8'h5A});
    @(negedge clk);
    chk(!prog_req, "R3 single pulse", prog_req, 0);

    grp(18'h05555, 8'h10);
    chk(chip_erase_req && erase_mask == 5'h1F, "R4 chip unlocked", erase_mask, 5'h1F);
    grp(18'h3A010, 8'h30);
    chk(sector_erase_req && erase_mask == 5'b01000, "R5 param1", erase_mask, 5'b01000);
    grp(18'h21000, 8'h30);
    chk(sector_erase_req && erase_mask == 5'b00010, "R5 main1", erase_mask, 5'b00010);
    grp(18'h39FFF, 8'h30);
    chk(sector_erase_req && erase_mask == 5'b00100, "R5 param2", erase_mask, 5'b00100);
    grp(18'h3C100, 8'h30);
    chk(sector_erase_req && erase_mask == 5'b10000, "R5 boot unlocked", erase_mask, 5'b10000);

    // R8 identification
    unlock(); wr(18'h05555, 8'h90);
    chk(id_mode, "R8 enter", id_mode, 1);
    rd(18'd0, "R8 mfr"); rd(18'd1, "R8 dev"); rd(18'd2, "R8 lock0"); rd(18'd3, "R8 other");
    // R9 exit with concurrent read
    @(negedge clk);
    wr_en = 1; wr_addr = 18'h12345; wr_data = 8'hF0; rd_en = 1; rd_addr = 18'd0;
    model(18'h12345, 8'hF0, 0, 0);
    #1;
    chk(id_hit && id_data == 8'hDA, "R9 read in exit cycle", {id_hit, id_data}, 9'h1DA);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk(!id_hit && !id_mode, "R9 single-write exit", {id_hit, id_mode}, 0);
    rd_en = 0;
    unlock(); wr(18'h05555, 8'h90);
    unlock(); wr(18'h05555, 8'hF0);
    chk(!id_mode, "R9 three-write exit", id_mode, 0);

    // R10 mismatch
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h56); wr(18'h05555, 8'hA0); wr(18'h00010, 8'h00);
    chk(!prog_req, "R10 mismatch", prog_req, 0);
    // R11 busy
    unlock(); wr(18'h05555, 8'hA0);
    wr(18'h00200, 8'h11, 1);
    chk(!prog_req, "R11 busy ignored", prog_req, 0);
    wr(18'h00201, 8'h22);
    chk(prog_req && op_addr == 18'h00201, "R11 step kept", op_addr, 18'h00201);

    // R6 lockout
    grp(18'h05555, 8'h40);
    chk(lock_set_req, "R6 lock set", lock_set_req, 1);
    unlock(); wr(18'h05555, 8'h90);
    rd(18'd2, "R6 lock visible");
    wr(18'h00000, 8'hF0);
    // R7 guard
    unlock(); wr(18'h05555, 8'hA0); wr(18'h3C005, 8'h00);
    chk(!prog_req, "R7 boot program blocked", prog_req, 0);
    unlock(); wr(18'h05555, 8'hA0); wr(18'h3C005, 8'h00, 0, 1);
    chk(prog_req, "R7 boot program override", prog_req, 1);
    grp(18'h3FFFF, 8'h30);
    chk(!sector_erase_req, "R7 boot erase blocked", sector_erase_req, 0);
    grp(18'h3FFFF, 8'h30, 1);
    chk(sector_erase_req, "R7 boot erase override", sector_erase_req, 1);
    grp(18'h05555, 8'h10);
    chk(chip_erase_req && erase_mask == 5'h0F, "R4 chip locked", erase_mask, 5'h0F);

    // R1 reset clears id, keeps lock
    unlock(); wr(18'h05555, 8'h90);
    do_reset();
    chk(!id_mode, "R1 id cleared", id_mode, 0);
    unlock(); wr(18'h05555, 8'h90);
    rd(18'd2, "R1 lock kept");
    wr(18'h00000, 8'hF0);

    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 3) begin
        logic [7:0] dv [9] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0, 8'h10, 8'h30, 8'h40};
        logic [17:0] a;
        a = $urandom;
        if ($urandom % 2) a[14:0] = ($urandom % 2) ? 15'h5555 : 15'h2AAA;
        wr(a, ($urandom % 4 == 0) ? 8'($urandom) : dv[$urandom % 9],
           $urandom % 8 == 0, $urandom % 2);
      end else if (r == 3) begin
        rd(18'($urandom % 4), "R8 random read");
      end else begin
        logic [7:0] c, f;
        logic [17:0] fa;
        c = (r < 6) ? 8'hA0 : (r < 8) ? 8'h80 : (r == 8) ? 8'h90 : 8'hF0;
        wr({3'($urandom), 15'h5555}, ($urandom % 20 == 0) ? 8'hAB : 8'hAA, $urandom % 10 == 0);
        wr({3'($urandom), 15'h2AAA}, 8'h55, $urandom % 10 == 0);
        wr({3'($urandom), 15'h5555}, c, $urandom % 10 == 0);
        if (c == 8'hA0) begin
          wr(18'($urandom), 8'($urandom), $urandom % 10 == 0, $urandom % 2);
        end else if (c == 8'h80) begin
          wr(18'h05555, 8'hAA);
          wr(18'h02AAA, ($urandom % 20 == 0) ? 8'h54 : 8'h55);
          case ($urandom % 4)
            0: begin fa = 18'h05555; f = 8'h10; end
            1: begin fa = 18'h05555; f = 8'hF0; end
            default: begin fa = 18'($urandom); f = 8'h30; end
          endcase
          wr(fa, f, $urandom % 10 == 0, $urandom % 2);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule